// File: doc/BRIEF.md
# Pointer-Addressed Host Register Interface

This block is the host-side slave of a two-channel serial controller. An 8-bit host bus reaches a large set of per-channel registers through a few control lines. These are a chip enable, read and write strobes, an interrupt-acknowledge qualifier, a channel select and a data/command select. Command accesses are indirect. A command write made while the shared pointer is zero stores the byte in register 0 of the addressed channel and loads the pointer from its low four bits. The next command access, read or write, on either channel goes to the register the pointer names, and the pointer then clears itself. Data accesses go straight to the channel's receive and transmit byte paths and leave the pointer alone.

All bus inputs are treated as synchronous to `clk`. An access opens on the first clock at which the qualified strobe is seen active. At that clock the kind of access, the channel, the data/command select and the current pointer are latched. The access closes on the first clock at which the strobe is seen inactive. At that point write data is committed, using the byte last sampled while the strobe was active. Read data appears on `dout` from the clock after the strobe is first seen and stays there until the access closes. The serial engines are outside this block. They supply the readable status registers and the received byte, and they consume the writable registers and the transmit byte.

Top module: `hbus_regif`

## Requirements
- R1: After reset the pointer is 0, all 28 writable registers read 8'h00 on `wr_regs`, and `dout` is 8'h00.
- R2: A command write (`data_sel`=0) while the pointer is 0 stores the whole byte in writable register 0 of the addressed channel and loads the pointer with bits [3:0] of that byte.
- R3: A command write while the pointer is nonzero stores the byte in the writable register the pointer selects, on the addressed channel. When that access closes, the pointer returns to 0.
- R4: A command read returns readable register `rd_regs` slot [pointer] of the addressed channel. A nonzero pointer returns to 0 when the read closes.
- R5: There is one pointer for both channels. It may be loaded through one channel and used by the next command access on the other channel.
- R6: A data read (`data_sel`=1) returns `rx_byte` of the addressed channel and pulses that channel's `rx_pop` once. A data write pulses that channel's `tx_load` for one clock with `tx_byte` set to the written byte. Neither kind of data access changes the pointer.
- R7: `chan_a`=1 selects channel A, which is index 1 in every flattened bus. `chan_a`=0 selects channel B, which is index 0. Register r of channel c sits at bits [(c*N+r)*8 +: 8].
- R8: While `iack_n` is low, activity on `ce_n`, `rd_n`, `wr_n`, `chan_a` and `data_sel` changes no register and no pointer, and `dout` stays 8'h00.
- R9: A strobe given while `ce_n` is high has no effect.
- R10: A pointer value of 14 or 15 makes the command write change no register. Pointer values 7 to 15 make the command read return 8'h00. In both cases the pointer still returns to 0.
- R11: Write data is taken from the last clock at which the write strobe was active, not from the first.
- R12: `dout` is 8'h00 whenever no read access is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce_n | input | 1 | Chip enable, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| iack_n | input | 1 | Interrupt acknowledge, active low; when low the bus is ignored |
| chan_a | input | 1 | Channel select: 1 = A, 0 = B |
| data_sel | input | 1 | 1 = data access, 0 = command access |
| din | input | 8 | Write data from host |
| dout | output | 8 | Read data to host |
| rd_regs | input | 112 | Readable registers, 7 per channel, from the serial engines |
| rx_byte | input | 16 | Received byte per channel |
| rx_pop | output | 2 | One-clock pulse per channel when its received byte was read |
| tx_load | output | 2 | One-clock pulse per channel when a transmit byte was written |
| tx_byte | output | 8 | Last transmit byte written |
| wr_regs | output | 224 | Writable registers, 14 per channel |

## Verification
The hardest state to reach from the ports is an ignored strobe arriving while the pointer holds a nonzero value. Such a strobe can be ruled harmless only by a later access. The stimulus loads the pointer first, then drives a full write strobe with interrupt acknowledge held low, and separately one with chip enable high. After each, the next command write must land in the register selected before the ignored strobe. Out-of-range pointers, pointer handover between channels, and data accesses slipped between the pointer load and the pointed access are reached the same way, by ordering legal bus cycles.

// File: rtl/hbus_regif_pkg.sv
package hbus_regif_pkg;
  localparam int NCH    = 2;   // channel count fixed by the single select line
  localparam int DATA_W = 8;
  localparam int PTR_W  = 4;
  localparam int N_WREG = 14;
  localparam int N_RREG = 7;
endpackage

// File: rtl/hbus_qual.sv
module hbus_qual #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          iack_n,
  input  logic          chan_a,
  input  logic          data_sel,
  input  logic [DW-1:0] din,
  output logic          busy,
  output logic          acc_start,
  output logic          acc_end,
  output logic          acc_wr,
  output logic          acc_ch,
  output logic          acc_dat,
  output logic [DW-1:0] wdata
);
  logic act_rd, act_wr, act;

  always_comb begin
    act_rd    = iack_n & ~ce_n & ~rd_n & wr_n;
    act_wr    = iack_n & ~ce_n & ~wr_n & rd_n;
    act       = act_rd | act_wr;
    acc_start = act & ~busy;
    acc_end   = busy & ~act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      acc_wr  <= 1'b0;
      acc_ch  <= 1'b0;
      acc_dat <= 1'b0;
      wdata   <= '0;
    end else begin
      busy <= act;
      if (acc_start) begin
        acc_wr  <= act_wr;
        acc_ch  <= chan_a;
        acc_dat <= data_sel;
      end
      if (act_wr) wdata <= din;
    end
  end
endmodule

// File: rtl/hbus_ptr.sv
module hbus_ptr #(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_start,
  input  logic          acc_end,
  input  logic          acc_wr,
  input  logic          acc_dat,
  input  logic [PW-1:0] wnib,
  output logic [PW-1:0] idx
);
  logic [PW-1:0] ptr, ptr_d;

  always_comb begin
    ptr_d = ptr;
    if (acc_end && !acc_dat)
      ptr_d = (acc_wr && idx == '0) ? wnib : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      idx <= '0;
    end else begin
      ptr <= ptr_d;
      if (acc_start) idx <= ptr;
    end
  end

  AST_PTR_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_end && !acc_dat && idx != '0) |=> (ptr == '0)); // R3

  AST_PTR_DATA_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_end && acc_dat) |=> (ptr == $past(ptr))); // R6
endmodule

// File: rtl/hbus_wregs.sv
module hbus_wregs #(
  parameter int NCH = 2,
  parameter int NWR = 14,
  parameter int DW  = 8,
  parameter int PW  = 4,
  parameter logic [DW-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_end,
  input  logic              acc_wr,
  input  logic              acc_dat,
  input  logic              acc_ch,
  input  logic [PW-1:0]     idx,
  input  logic [DW-1:0]     wdata,
  output logic [NCH*NWR*DW-1:0] wr_regs,
  output logic [NCH-1:0]    tx_load,
  output logic [DW-1:0]     tx_byte
);
  logic cmd_commit, dat_commit;

  always_comb begin
    cmd_commit = acc_end & acc_wr & ~acc_dat;
    dat_commit = acc_end & acc_wr &  acc_dat;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    for (genvar r = 0; r < NWR; r++) begin : g_reg
      logic we;
      always_comb we = cmd_commit && (acc_ch == 1'(c)) && (idx == PW'(r));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  wr_regs[(c*NWR+r)*DW +: DW] <= RST_VAL;
        else if (we) wr_regs[(c*NWR+r)*DW +: DW] <= wdata;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tx_load[c] <= 1'b0;
      else        tx_load[c] <= dat_commit && (acc_ch == 1'(c));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          tx_byte <= '0;
    else if (dat_commit) tx_byte <= wdata;
  end

  AST_WR_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_commit && idx >= PW'(NWR)) |=> $stable(wr_regs)); // R10

  AST_TX_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_load)); // R6
endmodule

// File: rtl/hbus_rmux.sv
module hbus_rmux #(
  parameter int NCH = 2,
  parameter int NRD = 7,
  parameter int DW  = 8,
  parameter int PW  = 4
) (
  input  logic              busy,
  input  logic              acc_wr,
  input  logic              acc_dat,
  input  logic              acc_ch,
  input  logic [PW-1:0]     idx,
  input  logic [NCH*NRD*DW-1:0] rd_regs,
  input  logic [NCH*DW-1:0] rx_byte,
  output logic [DW-1:0]     dout
);
  logic [DW-1:0] cmd_val, dat_val;

  always_comb begin
    cmd_val = '0;
    dat_val = '0;
    for (int c = 0; c < NCH; c++) begin
      if (acc_ch == 1'(c)) dat_val = rx_byte[c*DW +: DW];
      for (int i = 0; i < NRD; i++)
        if (acc_ch == 1'(c) && idx == PW'(i)) cmd_val = rd_regs[(c*NRD+i)*DW +: DW];
    end
    dout = '0;
    if (busy && !acc_wr) dout = acc_dat ? dat_val : cmd_val;
  end
endmodule

// File: rtl/hbus_regif.sv
module hbus_regif
  import hbus_regif_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int PW  = PTR_W,
  parameter int NWR = N_WREG,
  parameter int NRD = N_RREG,
  localparam int WR_BITS = NCH*NWR*DW,
  localparam int RD_BITS = NCH*NRD*DW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce_n,
  input  logic               rd_n,
  input  logic               wr_n,
  input  logic               iack_n,
  input  logic               chan_a,
  input  logic               data_sel,
  input  logic [DW-1:0]      din,
  output logic [DW-1:0]      dout,
  input  logic [RD_BITS-1:0] rd_regs,
  input  logic [NCH*DW-1:0]  rx_byte,
  output logic [NCH-1:0]     rx_pop,
  output logic [NCH-1:0]     tx_load,
  output logic [DW-1:0]      tx_byte,
  output logic [WR_BITS-1:0] wr_regs
);
  logic [1:0]    rst_sync;
  logic          rst_n_s;
  logic          busy, acc_start, acc_end, acc_wr, acc_ch, acc_dat;
  logic [DW-1:0] wdata;
  logic [PW-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  hbus_qual #(.DW(DW)) u_qual (
    .clk(clk), .rst_n(rst_n_s), .ce_n(ce_n), .rd_n(rd_n), .wr_n(wr_n),
    .iack_n(iack_n), .chan_a(chan_a), .data_sel(data_sel), .din(din),
    .busy(busy), .acc_start(acc_start), .acc_end(acc_end), .acc_wr(acc_wr),
    .acc_ch(acc_ch), .acc_dat(acc_dat), .wdata(wdata)
  );

  hbus_ptr #(.PW(PW)) u_ptr (
    .clk(clk), .rst_n(rst_n_s), .acc_start(acc_start), .acc_end(acc_end),
    .acc_wr(acc_wr), .acc_dat(acc_dat), .wnib(wdata[PW-1:0]), .idx(idx)
  );

  hbus_wregs #(.NCH(NCH), .NWR(NWR), .DW(DW), .PW(PW)) u_wregs (
    .clk(clk), .rst_n(rst_n_s), .acc_end(acc_end), .acc_wr(acc_wr),
    .acc_dat(acc_dat), .acc_ch(acc_ch), .idx(idx), .wdata(wdata),
    .wr_regs(wr_regs), .tx_load(tx_load), .tx_byte(tx_byte)
  );

  hbus_rmux #(.NCH(NCH), .NRD(NRD), .DW(DW), .PW(PW)) u_rmux (
    .busy(busy), .acc_wr(acc_wr), .acc_dat(acc_dat), .acc_ch(acc_ch),
    .idx(idx), .rd_regs(rd_regs), .rx_byte(rx_byte), .dout(dout)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_pop
    always_ff @(posedge clk or negedge rst_n_s) begin
      if (!rst_n_s) rx_pop[c] <= 1'b0;
      else          rx_pop[c] <= acc_end && !acc_wr && acc_dat && (acc_ch == 1'(c));
    end
  end

  AST_IACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!iack_n && !busy) |=> $stable(wr_regs)); // R8

  AST_DOUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($past(rd_n) && rd_n) |-> (dout == '0)); // R12

  AST_POP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0(rx_pop)); // R6
endmodule

// File: tb/tb_hbus_regif.sv
module tb_hbus_regif;
  localparam int CLK_PERIOD = 10;
  localparam int NWR = 14, NRD = 7;

  logic clk = 1'b0;
  logic rst_n, ce_n, rd_n, wr_n, iack_n, chan_a, data_sel;
  logic [7:0] din, dout, tx_byte;
  logic [2*NRD*8-1:0] rd_regs;
  logic [15:0] rx_byte;
  logic [1:0] rx_pop, tx_load;
  logic [2*NWR*8-1:0] wr_regs;

  always #(CLK_PERIOD/2) clk = ~clk;

  hbus_regif dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .rd_n(rd_n), .wr_n(wr_n),
    .iack_n(iack_n), .chan_a(chan_a), .data_sel(data_sel), .din(din),
    .dout(dout), .rd_regs(rd_regs), .rx_byte(rx_byte), .rx_pop(rx_pop),
    .tx_load(tx_load), .tx_byte(tx_byte), .wr_regs(wr_regs)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] wexp [2][NWR];
  logic [3:0] ptr_m;
  int tx_cnt [2];
  int pop_cnt [2];
  logic [7:0] exp_q [$];
  string tag_q [$];
  bit chk_go = 1'b0;

  function automatic logic [7:0] rr_val(input int c, input int i);
    return 8'(8'hA0 + c*16 + i);
  endfunction

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_regs(input string tag);
    logic bad = 1'b0;
    n_cmp++;
    for (int c = 0; c < 2; c++)
      for (int r = 0; r < NWR; r++)
        if (!bad && wr_regs[(c*NWR+r)*8 +: 8] !== wexp[c][r]) begin
          bad = 1'b1;
          n_bad++;
          $display("FAIL %s: ch%0d reg%0d actual %h expected %h",
                   tag, c, r, wr_regs[(c*NWR+r)*8 +: 8], wexp[c][r]);
        end
  endtask

  // monitor: pops expected read data and compares with dout
  always @(negedge clk) begin
    if (chk_go) begin
      chk_go = 1'b0;
      chk8(tag_q.pop_front(), dout, exp_q.pop_front());
    end
    for (int c = 0; c < 2; c++) begin
      if (tx_load[c]) tx_cnt[c]++;
      if (rx_pop[c])  pop_cnt[c]++;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // d_first is driven on the first strobe cycle, d on the last (R11)
  task automatic bus_write(input bit ch, input bit dat, input logic [7:0] d_first, input logic [7:0] d);
    @(negedge clk);
    ce_n = 0; wr_n = 0; chan_a = ch; data_sel = dat; din = d_first;
    @(negedge clk); din = d;
    @(negedge clk); ce_n = 1; wr_n = 1; din = 8'h00;
    idle(2);
    if (!dat) begin
      if (ptr_m == 0) begin wexp[ch][0] = d; ptr_m = d[3:0]; end
      else begin
        if (ptr_m < NWR) wexp[ch][ptr_m] = d;
        ptr_m = 0;
      end
    end
  endtask

  task automatic bus_read(input bit ch, input bit dat, input string tag);
    logic [7:0] e;
    if (dat) e = rx_byte[ch*8 +: 8];
    else     e = (ptr_m < NRD) ? rr_val(ch, ptr_m) : 8'h00;
    @(negedge clk);
    ce_n = 0; rd_n = 0; chan_a = ch; data_sel = dat;
    @(posedge clk);
    exp_q.push_back(e); tag_q.push_back(tag); chk_go = 1'b1;
    @(negedge clk); ce_n = 1; rd_n = 1;
    idle(2);
    if (!dat) ptr_m = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ce_n = 1; rd_n = 1; wr_n = 1; iack_n = 1; chan_a = 0; data_sel = 0; din = 0;
    for (int c = 0; c < 2; c++) begin
      tx_cnt[c] = 0; pop_cnt[c] = 0;
      for (int i = 0; i < NRD; i++) rd_regs[(c*NRD+i)*8 +: 8] = rr_val(c, i);
      for (int r = 0; r < NWR; r++) wexp[c][r] = 8'h00;
    end
    rx_byte = {8'h5A, 8'h5B};   // A (index 1) = 5A, B (index 0) = 5B
    ptr_m = 0;
    idle(4); rst_n = 1; idle(4);

    // R1 reset state
    chk_regs("R1 regs after reset");
    chk8("R1 dout after reset", dout, 8'h00);

    // R2 load pointer through register 0; R11 last strobe byte wins
    bus_write(1, 0, 8'hFF, 8'h35);
    chk_regs("R2 reg0 A and pointer load, R11 trailing data");
    // R3 pointed write, pointer clears
    bus_write(1, 0, 8'h00, 8'h77);
    chk_regs("R3 pointed write A reg5");
    // R7 channel B
    bus_write(0, 0, 8'h42, 8'h42);
    bus_write(0, 0, 8'h99, 8'h99);
    chk_regs("R7 channel B reg0 and reg2");
    // R5 shared pointer: load via A, use via B
    bus_write(1, 0, 8'h03, 8'h03);
    bus_write(0, 0, 8'h11, 8'h11);
    chk_regs("R5 pointer handover A to B");
    // R4 command read through pointer, then pointer back to 0
    bus_write(0, 0, 8'h04, 8'h04);
    bus_read(1, 0, "R4 pointed read A slot4");
    bus_read(0, 0, "R4 read after clear B slot0");
    // R6 data accesses between pointer load and pointed access
    bus_write(1, 0, 8'h06, 8'h06);
    bus_write(0, 1, 8'h00, 8'hC3);
    bus_read(1, 1, "R6 data read A");
    bus_read(0, 1, "R6 data read B");
    bus_write(1, 0, 8'h12, 8'hEE);
    chk_regs("R6 pointer kept across data accesses");
    chk8("R6 tx byte", tx_byte, 8'hC3);
    chk8("R6 tx pulses B", 8'(tx_cnt[0]), 8'd1);
    chk8("R6 tx pulses A", 8'(tx_cnt[1]), 8'd0);
    chk8("R6 rx pops A", 8'(pop_cnt[1]), 8'd1);
    chk8("R6 rx pops B", 8'(pop_cnt[0]), 8'd1);

    // R8 strobes ignored under interrupt acknowledge
    bus_write(1, 0, 8'h07, 8'h07);
    @(negedge clk);
    iack_n = 0; ce_n = 0; wr_n = 0; chan_a = 1; data_sel = 0; din = 8'h0D;
    idle(3);
    wr_n = 1; rd_n = 0;
    idle(2);
    chk8("R8 dout under iack", dout, 8'h00);
    ce_n = 1; rd_n = 1; iack_n = 1;
    idle(2);
    chk_regs("R8 no change under iack");
    bus_write(1, 0, 8'h5C, 8'h5C);
    chk_regs("R8 pointer kept under iack");

    // R9 strobe without chip enable
    bus_write(0, 0, 8'h08, 8'h08);
    @(negedge clk);
    ce_n = 1; wr_n = 0; chan_a = 0; data_sel = 0; din = 8'h66;
    idle(3);
    wr_n = 1;
    idle(2);
    bus_write(0, 0, 8'h3D, 8'h3D);
    chk_regs("R9 pointer kept without chip enable");

    // R10 out-of-range pointer values
    bus_write(1, 0, 8'h0E, 8'h0E);
    bus_write(1, 0, 8'hFF, 8'hFF);
    chk_regs("R10 write with pointer 14 dropped");
    bus_read(1, 0, "R10 pointer cleared after dropped write");
    bus_write(0, 0, 8'h09, 8'h09);
    bus_read(0, 0, "R10 read slot9 gives zero");
    bus_read(0, 0, "R10 pointer cleared after read");

    // R12 idle dout
    idle(2);
    chk8("R12 idle dout", dout, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule